// File: doc/BRIEF.md
# Descriptor-Driven Single-Channel DMA Engine

This block moves data for one channel under the control of a three-word descriptor held in ordinary memory. The descriptor gives the last source address, the last destination address and a control word. The engine reaches memory through a single synchronous port. That port carries descriptor fetches, element reads, element writes and the write-back of the control word. Memory returns read data on the cycle after the address.

Two descriptors belong to the channel: a primary one at `PRI_BASE` and an alternate one at `ALT_BASE`. Each occupies three consecutive addresses: source end, destination end, control. Software builds a descriptor and pulses `en_set` with `alt_sel` choosing the descriptor. It then either pulses `sw_req` or lets a peripheral raise single or burst requests. After each request the engine writes the remaining count back into the control word. A finished descriptor is written back with its cycle type set to stop.

Three cycle types are handled:
- **Basic** moves data only on peripheral requests.
- **Auto** runs to the end from one software request.
- **Ping-pong** flips between the primary and the alternate descriptor each time one completes.

Top module: `dma_desc_engine`

## Requirements
- R1: After reset `chan_en`, `done` and `mem_we` are low, and no memory write happens while `chan_en` is low.
- R2: The control word holds the cycle type in bits [2:0], the burst-only flag in [3], the count minus one in [13:4], the arbitration exponent R in [17:14], the source increment in [21:20] and the destination increment in [23:22]. Increment codes 0, 1 and 2 step the address by 1, 2 and 4. Code 3 means no increment. Element k of a descriptor with count-minus-one n is read at source_end - ((n-k) << inc) and written at the destination address found the same way.
- R3: With cycle type 2 (auto), one `sw_req` moves every element with no further request. The control word is then written back with type 0 and count field 0. `done` pulses for exactly one cycle, and `chan_en` is low from that cycle on.
- R4: With cycle type 1 (basic), `sw_req` moves nothing. A single peripheral request moves one element. A burst request moves 2^R elements, or fewer if fewer remain.
- R5: A request that leaves elements outstanding writes the control word back with the count field equal to the remaining elements minus one and the type unchanged. It raises no `done`, and `chan_en` stays high.
- R6: When the burst-only flag is set, single peripheral requests move nothing, while burst requests are still served.
- R7: With cycle type 3 (ping-pong), the engine starts on the descriptor chosen by `alt_sel`. When that descriptor completes, `cur_alt` flips, `chan_en` stays high and no `done` pulse is given.
- R8: When the fetched descriptor carries type 0 or a type of 4 or above, the engine moves nothing, writes nothing and clears `chan_en` without a `done` pulse.
- R9: An auto descriptor ignores peripheral requests: its count and the destination stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_set | input | 1 | Pulse that enables the channel while it is disabled |
| alt_sel | input | 1 | Descriptor chosen on `en_set`: 0 primary, 1 alternate |
| sw_req | input | 1 | Software request strobe |
| periph_req | input | 1 | Peripheral single request |
| periph_breq | input | 1 | Peripheral burst request |
| chan_en | output | 1 | Channel enable, cleared by the engine at the end of a cycle |
| cur_alt | output | 1 | Descriptor in use: 0 primary, 1 alternate |
| done | output | 1 | One-cycle pulse at the end of a basic or auto cycle |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after the address |

## Verification
The hardest state to reach from the ports is the ping-pong stall. In that state the engine has flipped to a descriptor that software has not refreshed, and the next request must stop the channel without a `done` pulse. The stimulus runs the primary descriptor and then the alternate descriptor to completion, leaving both written back as stop. A further burst request then makes the engine fetch a stale descriptor. Partial progress is made visible the same way: the bench reads the written-back count in memory after each single or burst request.

// File: rtl/dma_desc_engine.sv
module dma_desc_engine #(
  parameter int AW = 10,
  parameter logic [AW-1:0] PRI_BASE = AW'(1008),
  parameter logic [AW-1:0] ALT_BASE = AW'(1016)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_set,
  input  logic          alt_sel,
  input  logic          sw_req,
  input  logic          periph_req,
  input  logic          periph_breq,
  output logic          chan_en,
  output logic          cur_alt,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  localparam int NW = 10;
  localparam logic [2:0] T_BASIC = 3'd1, T_AUTO = 3'd2, T_PP = 3'd3;

  typedef enum logic [2:0] {S_IDLE, S_F0, S_F1, S_F2, S_CTL, S_RD, S_WR, S_WB} st_t;
  st_t st;

  logic [AW-1:0] src_end, dst_end;
  logic [31:0]   ctrl;
  logic [NW-1:0] rem;
  logic [NW:0]   left;
  logic          by_sw, by_burst, fin;

  function automatic logic [AW-1:0] back_off(input logic [NW-1:0] r, input logic [1:0] code);
    logic [AW-1:0] x;
    x = AW'(r);
    return (code == 2'd3) ? '0 : (x << code);
  endfunction

  wire [AW-1:0] base    = cur_alt ? ALT_BASE : PRI_BASE;
  wire [2:0]    r_type  = mem_rdata[2:0];
  wire          r_bad   = (r_type == 3'd0) || r_type[2];
  wire [3:0]    r_arb   = mem_rdata[17:14];
  wire [NW:0]   r_chunk = (r_arb >= 4'(NW)) ? (NW+1)'(1) << NW : (NW+1)'(1) << r_arb;
  wire          r_ok    = (r_type == T_AUTO) ? by_sw
                        : (!by_sw && (by_burst || !mem_rdata[3]));
  wire          is_auto = (ctrl[2:0] == T_AUTO);
  wire [31:0]   wb_word = fin ? {ctrl[31:14], {NW{1'b0}}, ctrl[3], 3'd0}
                              : {ctrl[31:14], rem, ctrl[3:0]};

  always_comb begin
    case (st)
      S_F0:    mem_addr = base;
      S_F1:    mem_addr = base + AW'(1);
      S_F2:    mem_addr = base + AW'(2);
      S_RD:    mem_addr = src_end - back_off(rem, ctrl[21:20]);
      S_WR:    mem_addr = dst_end - back_off(rem, ctrl[23:22]);
      S_WB:    mem_addr = base + AW'(2);
      default: mem_addr = '0;
    endcase
  end
  assign mem_we    = (st == S_WR) || (st == S_WB);
  assign mem_wdata = (st == S_WR) ? mem_rdata : wb_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; chan_en <= 1'b0; cur_alt <= 1'b0; done <= 1'b0;
      src_end <= '0; dst_end <= '0; ctrl <= '0; rem <= '0; left <= '0;
      by_sw <= 1'b0; by_burst <= 1'b0; fin <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (!chan_en && en_set) begin
            chan_en <= 1'b1;
            cur_alt <= alt_sel;
          end else if (chan_en && (sw_req || periph_req || periph_breq)) begin
            by_sw    <= sw_req;
            by_burst <= periph_breq;
            st       <= S_F0;
          end
        end
        S_F0: st <= S_F1;
        S_F1: begin src_end <= mem_rdata[AW-1:0]; st <= S_F2; end
        S_F2: begin dst_end <= mem_rdata[AW-1:0]; st <= S_CTL; end
        S_CTL: begin
          ctrl <= mem_rdata;
          rem  <= mem_rdata[13:4];
          left <= (by_sw || by_burst) ? r_chunk : (NW+1)'(1);
          fin  <= 1'b0;
          if (r_bad) begin
            chan_en <= 1'b0;
            st      <= S_IDLE;
          end else if (r_ok) st <= S_RD;
          else st <= S_IDLE;
        end
        S_RD: st <= S_WR;
        S_WR: begin
          if (rem == '0) begin
            fin <= 1'b1;
            st  <= S_WB;
          end else begin
            rem <= rem - NW'(1);
            if (!is_auto && left == (NW+1)'(1)) st <= S_WB;
            else begin
              left <= left - (NW+1)'(1);
              st   <= S_RD;
            end
          end
        end
        S_WB: begin
          if (fin) begin
            if (ctrl[2:0] == T_PP) cur_alt <= ~cur_alt;
            else begin
              chan_en <= 1'b0;
              done    <= 1'b1;
            end
          end
          fin <= 1'b0;
          st  <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_write_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> chan_en);
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_done_drops_en: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !chan_en);
  a_r7_flip_keeps_en: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(en_set) && cur_alt != $past(cur_alt)) |-> (chan_en && !done));
  a_r8_bad_type_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CTL && r_bad) |=> (!chan_en && !done && !mem_we));
  a_r4_basic_no_sw: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CTL && r_type == T_BASIC && by_sw) |=> (st == S_IDLE && !mem_we));
endmodule

// File: tb/dma_desc_engine_tb_top.sv
`timescale 1ns/1ps
module dma_desc_engine_tb_top;
  localparam int AW = 10;
  localparam int PRI = 1008, ALT = 1016;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_set = 0, alt_sel = 0, sw_req = 0, periph_req = 0, periph_breq = 0;
  logic chan_en, cur_alt, done, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic tb_we = 0;
  logic [AW-1:0] tb_addr = '0;
  logic [31:0] tb_data = '0;
  logic [31:0] mem [1024];
  int n_chk = 0, n_bad = 0, done_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_desc_engine #(.AW(AW), .PRI_BASE(AW'(PRI)), .ALT_BASE(AW'(ALT))) dut_i (
    .clk(clk), .rst_n(rst_n), .en_set(en_set), .alt_sel(alt_sel), .sw_req(sw_req),
    .periph_req(periph_req), .periph_breq(periph_breq), .chan_en(chan_en),
    .cur_alt(cur_alt), .done(done), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (rst_n && done) done_cnt <= done_cnt + 1;
  end

  localparam int V_N  [6] = '{0, 7, 5, 4, 3, 255};
  localparam int V_SI [6] = '{2, 0, 1, 3, 2, 0};
  localparam int V_DI [6] = '{2, 0, 2, 0, 3, 0};
  localparam int V_S  [6] = '{16, 32, 64, 96, 128, 256};
  localparam int V_D  [6] = '{512, 528, 544, 576, 608, 672};

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk); tb_we = 1; tb_addr = AW'(a); tb_data = d;
    @(negedge clk); tb_we = 0;
  endtask

  task automatic pulse_sw();   @(negedge clk); sw_req = 1;      @(negedge clk); sw_req = 0;      endtask
  task automatic pulse_pr();   @(negedge clk); periph_req = 1;  @(negedge clk); periph_req = 0;  endtask
  task automatic pulse_br();   @(negedge clk); periph_breq = 1; @(negedge clk); periph_breq = 0; endtask
  task automatic start(input bit a);
    @(negedge clk); en_set = 1; alt_sel = a; @(negedge clk); en_set = 0;
  endtask
  task automatic settle(); repeat (40) @(negedge clk); endtask

  function automatic logic [31:0] mk_ctrl(input int typ, input bit bo, input int n,
                                          input int arb, input int si, input int di);
    return {8'h0, 2'(di), 2'(si), 2'b0, 4'(arb), 10'(n), bo, 3'(typ)};
  endfunction
  function automatic int end_of(input int s, input int n, input int inc);
    return (inc == 3) ? s : s + (n << inc);
  endfunction
  task automatic put_desc(input int b, input int s, input int d, input logic [31:0] c);
    poke(b, 32'(end_of(s, int'(c[13:4]), int'(c[21:20]))));
    poke(b + 1, 32'(end_of(d, int'(c[13:4]), int'(c[23:22]))));
    poke(b + 2, c);
  endtask

  initial begin
    #(20ns * 200000);
    check(0, "watchdog", 0, 1);
    if (!finished) $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!chan_en && !done && !mem_we, "R1 reset outputs", {chan_en, done, mem_we}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!chan_en, "R1 idle after reset", chan_en, 0);

    // R2 / R3: auto copies across the vector table
    for (int v = 0; v < 6; v++) begin
      int dc, w;
      for (int k = 0; k <= V_N[v]; k++) begin
        poke(V_S[v] + ((V_SI[v] == 3) ? 0 : k << V_SI[v]), 32'hA5000000 | 32'(k * 3 + v));
        poke(V_D[v] + ((V_DI[v] == 3) ? 0 : k << V_DI[v]), 32'h0);
      end
      put_desc(PRI, V_S[v], V_D[v], mk_ctrl(2, 0, V_N[v], 0, V_SI[v], V_DI[v]));
      dc = done_cnt;
      start(0);
      pulse_sw();
      w = 0;
      while (done_cnt == dc && w < 5000) begin @(negedge clk); w++; end
      check(done_cnt == dc + 1, "R3 auto done pulse", done_cnt - dc, 1);
      check(!chan_en, "R3 enable cleared", chan_en, 0);
      check(mem[PRI + 2][13:0] == 14'h0, "R3 writeback stop/count0", mem[PRI + 2][13:0], 0);
      if (V_DI[v] == 3) begin
        logic [31:0] e;
        e = (V_SI[v] == 3) ? (32'hA5000000 | 32'(V_N[v] * 3 + v)) : 32'hA5000000 | 32'(V_N[v] * 3 + v);
        check(mem[V_D[v]] == e, "R2 fixed destination holds last", mem[V_D[v]], e);
      end else begin
        for (int k = 0; k <= V_N[v]; k++) begin
          logic [31:0] e;
          e = 32'hA5000000 | 32'(((V_SI[v] == 3) ? V_N[v] : k) * 3 + v);
          check(mem[V_D[v] + (k << V_DI[v])] == e, "R2 element address", mem[V_D[v] + (k << V_DI[v])], e);
        end
      end
    end

    // R9: auto descriptor ignores peripheral requests
    for (int k = 0; k < 4; k++) begin poke(700 + k, 32'h77000000 + 32'(k)); poke(720 + k, 0); end
    put_desc(PRI, 700, 720, mk_ctrl(2, 0, 3, 1, 0, 0));
    start(0);
    pulse_br(); settle();
    check(mem[PRI + 2][13:4] == 10'd3 && mem[720] == 0, "R9 auto ignores periph", mem[PRI + 2][13:4], 3);
    check(chan_en, "R9 enable kept", chan_en, 1);
    pulse_sw(); settle();
    check(mem[723] == 32'h77000003 && !chan_en, "R3 auto completes later", mem[723], 32'h77000003);

    // R4 / R5 / R6: basic cycle in pieces
    for (int k = 0; k < 6; k++) begin poke(768 + k, 32'h3B000000 + 32'(k)); poke(784 + k, 0); end
    put_desc(PRI, 768, 784, mk_ctrl(1, 0, 5, 1, 0, 0));
    begin
      int dc;
      dc = done_cnt;
      start(0);
      pulse_sw(); settle();
      check(mem[PRI + 2][13:4] == 10'd5 && mem[784] == 0, "R4 sw_req ignored by basic", mem[PRI + 2][13:4], 5);
      pulse_pr(); settle();
      check(mem[PRI + 2][13:4] == 10'd4, "R5 count after single", mem[PRI + 2][13:4], 4);
      check(mem[PRI + 2][2:0] == 3'd1, "R5 type kept", mem[PRI + 2][2:0], 1);
      check(mem[784] == 32'h3B000000 && mem[785] == 0, "R4 single moves one", mem[785], 0);
      pulse_br(); settle();
      check(mem[PRI + 2][13:4] == 10'd2 && mem[786] == 32'h3B000002, "R4 burst moves 2^R", mem[PRI + 2][13:4], 2);
      check(done_cnt == dc && chan_en, "R5 no done while partial", done_cnt - dc, 0);
      poke(PRI + 2, mk_ctrl(1, 1, 2, 1, 0, 0));
      pulse_pr(); settle();
      check(mem[PRI + 2][13:4] == 10'd2 && mem[787] == 0, "R6 burst-only ignores single", mem[PRI + 2][13:4], 2);
      pulse_br(); settle();
      check(mem[PRI + 2][13:4] == 10'd0 && mem[788] == 32'h3B000004, "R6 burst served", mem[PRI + 2][13:4], 0);
      pulse_br(); settle();
      check(mem[789] == 32'h3B000005 && mem[PRI + 2][2:0] == 3'd0, "R4 last element and stop", mem[789], 32'h3B000005);
      check(done_cnt == dc + 1 && !chan_en, "R3 basic done at end", done_cnt - dc, 1);
    end

    // R7 / R8: ping-pong then stall on a stale descriptor
    for (int k = 0; k < 3; k++) begin
      poke(800 + k, 32'h50000000 + 32'(k)); poke(804 + k, 32'h60000000 + 32'(k));
      poke(816 + k, 0); poke(820 + k, 0);
    end
    put_desc(PRI, 800, 816, mk_ctrl(3, 0, 1, 2, 0, 0));
    put_desc(ALT, 804, 820, mk_ctrl(3, 0, 2, 2, 0, 0));
    begin
      int dc;
      dc = done_cnt;
      start(0);
      check(!cur_alt, "R7 starts on primary", cur_alt, 0);
      pulse_br(); settle();
      check(cur_alt && chan_en, "R7 flips to alternate", {cur_alt, chan_en}, 3);
      check(mem[817] == 32'h50000001 && mem[PRI + 2][2:0] == 0, "R7 primary moved", mem[817], 32'h50000001);
      pulse_br(); settle();
      check(!cur_alt && chan_en, "R7 flips back", {cur_alt, chan_en}, 1);
      check(mem[822] == 32'h60000002, "R7 alternate moved", mem[822], 32'h60000002);
      check(done_cnt == dc, "R7 no done in ping-pong", done_cnt - dc, 0);
      poke(816, 32'hDEAD);
      pulse_br(); settle();
      check(!chan_en && done_cnt == dc, "R8 stale descriptor halts", chan_en, 0);
      check(mem[816] == 32'hDEAD && mem[PRI + 2][13:0] == 0, "R8 nothing written", mem[816], 32'hDEAD);
    end

    // R8: unsupported type from the start
    poke(ALT + 2, mk_ctrl(5, 0, 2, 0, 0, 0));
    start(1);
    pulse_sw(); settle();
    check(!chan_en && mem[ALT + 2][2:0] == 3'd5, "R8 type 5 halts", chan_en, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule